// File: doc/BRIEF.md
# Read-Armed Event Flag Register

This block holds one sticky flag for each of up to eight capture/compare channels. A channel raises its flag with a single-cycle event pulse. All flags appear together in one register word, so a single read shows software every pending channel. A flag only clears when a write of zero reaches that bit and an earlier read had already seen the flag set. An event that arrives after that read cancels the arming, so the event is never lost.

Each channel keeps an arm bit next to its flag. A read strobe copies the current flags into the arm bits. A write strobe then clears the armed flags that are written as zero, and it discards every arm bit. Any channel event also clears that channel's arm bit. The interrupt request is the OR of all flags, each gated by its own enable input. A parameter selects whether the request is driven straight from the flags or through one register stage.

Top module: `evt_flag_bank`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every flag and every arm bit is 0, `rd_data_o` is 0 and `irq_o` is 0.
- R2: An event pulse on channel i sets flag i at the next clock edge. `rd_data_o` bit i shows flag i for i below NUM_CH. Bits NUM_CH and above always read 0, whatever was written to them.
- R3: A write strobe with bit i of `wr_data_i` at 0 clears flag i only if a read strobe saw flag i at 1 and no write or event on that channel came between that read and this write.
- R4: A write strobe with bit i at 1 leaves flag i unchanged.
- R5: A zero write to a flag that no read has armed leaves the flag set.
- R6: An event on channel i after the arming read and before the clearing write keeps flag i set through that write.
- R7: If an event pulse and an armed clearing write reach the same channel in the same cycle, the flag stays set.
- R8: Every write strobe consumes all arm bits. A second zero write that has no fresh read in front of it clears nothing.
- R9: When the read and write strobes come in the same cycle, the write uses the arm bits from earlier reads, and that read arms nothing.
- R10: With the default combinational interrupt mode, `irq_o` is 1 exactly when some channel has both its flag and `ien_i` bit at 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_CH | Per-channel single-cycle event pulses |
| ien_i | input | NUM_CH | Per-channel interrupt enables |
| rd_stb_i | input | 1 | Single-cycle register read strobe (arms the flags it sees) |
| wr_stb_i | input | 1 | Single-cycle register write strobe |
| wr_data_i | input | DATA_W | Write data; a 0 clears an armed flag |
| rd_data_o | output | DATA_W | Flag word, zero above NUM_CH |
| irq_o | output | 1 | Combined, enable-gated interrupt request |

## Verification
The hardest case to reach from the ports is an event that lands inside the read-to-write window, or in the same cycle as the clearing write, on a channel that was armed. Random stimulus rarely lines up those three actions on one channel. Directed sequences therefore read, fire the event in the gap or in the write cycle, and then zero-write. A long random run with sparse events and frequent strobes then mixes reads, writes, combined read-write cycles and events, and compares each cycle with a bench model built from the requirements.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;
   localparam int MAX_CH = 8;
   typedef enum logic {IRQ_COMB = 1'b0, IRQ_REG = 1'b1} irq_mode_e;
endpackage

// File: rtl/evt_flag_cell.sv
module evt_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o,
   output logic arm_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         arm_o  <= 1'b0;
      end else begin
         if (evt_i)
            flag_o <= 1'b1;
         else if (wr_i && !wbit_i && arm_o)
            flag_o <= 1'b0;
         if (evt_i || wr_i)
            arm_o <= 1'b0;
         else if (rd_i)
            arm_o <= flag_o;
      end
   end

   p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_o);
   p_one_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wbit_i && !evt_i) |=> flag_o == $past(flag_o));
   p_unarmed_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !arm_o && !evt_i) |=> flag_o == $past(flag_o));
   p_fall_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> ($past(arm_o) && $past(wr_i)));
   p_evt_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> !arm_o);
   p_wr_consumes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> !arm_o);
   p_arm_has_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      arm_o |-> flag_o);
endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge
   import evt_flag_pkg::*;
#(
   parameter int        NUM_CH   = 8,
   parameter irq_mode_e IRQ_MODE = IRQ_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] flag_i,
   input  logic [NUM_CH-1:0] ien_i,
   output logic              irq_o
);
   logic pend;
   assign pend = |(flag_i & ien_i);

   generate
      if (IRQ_MODE == IRQ_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= pend;
         end
      end else begin : g_comb
         assign irq_o = pend;
      end
   endgenerate
endmodule

// File: rtl/evt_rd_pack.sv
module evt_rd_pack #(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 32
) (
   input  logic [NUM_CH-1:0] flag_i,
   output logic [DATA_W-1:0] word_o
);
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b < NUM_CH) begin : g_live
            assign word_o[b] = flag_i[b];
         end else begin : g_zero
            assign word_o[b] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
   import evt_flag_pkg::*;
#(
   parameter int        NUM_CH   = 8,
   parameter int        DATA_W   = 32,
   parameter irq_mode_e IRQ_MODE = IRQ_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_i,
   input  logic [NUM_CH-1:0] ien_i,
   input  logic              rd_stb_i,
   input  logic              wr_stb_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);
   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH || NUM_CH > DATA_W) begin : g_bad_cfg
         $error("evt_flag_bank: NUM_CH out of range");
      end
   endgenerate

   logic [NUM_CH-1:0] flag;
   logic [NUM_CH-1:0] arm;
   logic              unused_wdata;
   assign unused_wdata = ^wr_data_i;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         evt_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_i[c]),
            .rd_i   (rd_stb_i),
            .wr_i   (wr_stb_i),
            .wbit_i (wr_data_i[c]),
            .flag_o (flag[c]),
            .arm_o  (arm[c])
         );
      end
   endgenerate

   evt_rd_pack #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_pack (
      .flag_i (flag),
      .word_o (rd_data_o)
   );

   evt_irq_merge #(.NUM_CH(NUM_CH), .IRQ_MODE(IRQ_MODE)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (flag),
      .ien_i  (ien_i),
      .irq_o  (irq_o)
   );

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (flag == '0 && arm == '0));
   p_wr_rd_noarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && wr_stb_i) |=> arm == '0);
   p_evt_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb_i && evt_i != '0) |=> ((rd_data_o[NUM_CH-1:0] & $past(evt_i)) == $past(evt_i)));
   generate
      if (IRQ_MODE == IRQ_COMB) begin : g_irq_chk
         p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ((rd_data_o[NUM_CH-1:0] & ien_i) == '0) |-> !irq_o);
         p_pending_fires_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ((rd_data_o[NUM_CH-1:0] & ien_i) != '0) |-> irq_o);
      end
      if (NUM_CH < DATA_W) begin : g_hi_chk
         p_upper_zero_r2: assert property (@(posedge clk)
            rd_data_o[DATA_W-1:NUM_CH] == '0);
      end
   endgenerate
endmodule

// File: tb/tb_evt_flag_bank.sv
module tb_evt_flag_bank;
   localparam int NCH = 8;
   localparam int DW  = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] evt = '0;
   logic [NCH-1:0] ien = '0;
   logic           rd = 1'b0;
   logic           wr = 1'b0;
   logic [DW-1:0]  wd = '0;
   logic [DW-1:0]  rdata;
   logic           irq;

   int checks = 0;
   int errors = 0;
   logic [NCH-1:0] mflag = '0;
   logic [NCH-1:0] marm  = '0;

   always #2 clk = ~clk;

   evt_flag_bank #(.NUM_CH(NCH), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .ien_i(ien),
      .rd_stb_i(rd), .wr_stb_i(wr), .wr_data_i(wd),
      .rd_data_o(rdata), .irq_o(irq)
   );

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   function automatic logic [NCH-1:0] nxt_flag(logic [NCH-1:0] f, logic [NCH-1:0] a,
                                               logic [NCH-1:0] e, logic w, logic [NCH-1:0] d);
      return e | (f & ~(a & ~d & {NCH{w}}));
   endfunction

   function automatic logic [NCH-1:0] nxt_arm(logic [NCH-1:0] f, logic [NCH-1:0] a,
                                              logic [NCH-1:0] e, logic r, logic w);
      if (w) return '0;
      return (r ? f : a) & ~e;
   endfunction

   task automatic chk_word(string tag, logic [DW-1:0] exp);
      checks++;
      if (rdata !== exp) begin
         errors++;
         $display("FAIL %s rd_data actual %h expected %h", tag, rdata, exp);
      end
   endtask

   task automatic chk_irq(string tag, logic exp);
      checks++;
      if (irq !== exp) begin
         errors++;
         $display("FAIL %s irq actual %b expected %b", tag, irq, exp);
      end
   endtask

   task automatic step(string tag, logic [NCH-1:0] e, logic r, logic w,
                       logic [DW-1:0] d, logic [NCH-1:0] ie);
      @(negedge clk);
      evt = e; rd = r; wr = w; wd = d; ien = ie;
      #1;
      chk_irq({tag, " R10"}, |(mflag & ie));
      @(posedge clk);
      mflag = nxt_flag(mflag, marm, e, w, d[NCH-1:0]);
      marm  = nxt_arm(mflag_prev, marm, e, r, w);
      @(negedge clk);
      evt = '0; rd = 1'b0; wr = 1'b0;
      chk_word(tag, {{(DW-NCH){1'b0}}, mflag});
   endtask

   logic [NCH-1:0] mflag_prev;
   always @(posedge clk) mflag_prev <= mflag;

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_word("R1 in reset", '0);
      chk_irq("R1 in reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_word("R1 after reset", '0);
      chk_irq("R1 after reset", 1'b0);

      step("R2 set ch0 ch5", 8'h21, 0, 0, '0, '0);
      step("R2 upper write ignored", 8'h00, 0, 0, 32'hFFFF_FF00, 8'h00);
      step("R10 enable ch5", 8'h00, 0, 0, '0, 8'h20);
      step("R5 unarmed zero write", 8'h00, 0, 1, '0, 8'h01);
      step("R3 arm read", 8'h00, 1, 0, '0, 8'h00);
      step("R4 write ones keeps", 8'h00, 0, 1, 32'hFF, 8'h00);
      step("R8 rearm read", 8'h00, 1, 0, '0, 8'h00);
      step("R3 clear ch0 only", 8'h00, 0, 1, 32'hFE, 8'h00);
      step("R8 no read second zero", 8'h00, 0, 1, '0, 8'h00);
      step("R6 set ch3", 8'h08, 0, 0, '0, 8'h00);
      step("R6 arm read", 8'h00, 1, 0, '0, 8'h00);
      step("R6 event in gap", 8'h08, 0, 0, '0, 8'h00);
      step("R6 zero write", 8'h00, 0, 1, '0, 8'h08);
      step("R7 arm read", 8'h00, 1, 0, '0, 8'h00);
      step("R7 event with write", 8'h08, 0, 1, '0, 8'h00);
      step("R9 rd+wr same cycle", 8'h00, 1, 1, '0, 8'h00);
      step("R9 following zero write", 8'h00, 0, 1, '0, 8'h00);
      step("R3 arm all", 8'h00, 1, 0, '0, 8'h00);
      step("R3 clear all 0x00", 8'h00, 0, 1, '0, 8'hFF);

      for (int i = 0; i < 3000; i++) begin
         logic [NCH-1:0] e;
         e = '0;
         for (int c = 0; c < NCH; c++) if ($urandom_range(0, 9) == 0) e[c] = 1'b1;
         step("R3 random", e, ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
              $urandom, NCH'($urandom));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule